// File: doc/BRIEF.md
# Channel-Interleaved Systolic FIR Filter

This block runs one multiply-accumulate array for several independent FIR filters at once. Each enabled clock it accepts one sample, taken from the channel whose turn it is. The channels are visited 0, 1, ..., N-1 and then the cycle repeats, so each channel runs at the clock rate divided by the channel count. Every channel has its own tap coefficients, and those coefficients may be any signed values. The channel interleave is built into the array's register spacing. Samples of one channel therefore combine only with that channel's own earlier samples, so the result is the same as N separate filters.

Channel 0's first sample is marked with a valid strobe. A full-precision accumulator then feeds a formatting stage. That stage applies optional symmetric rounding and an optional clamp, and then writes the result to that channel's own output bus. A valid flag rises with channel 0's first result. After that, one channel's output bus is refreshed on each enabled clock, in channel order. A low clock enable freezes every register. The channel count, tap count, sample width, coefficient width, fraction bits, rounding, clamping and the coefficient sets are all parameters.

Top module: `interleaved_fir`

## Requirements
- R1: The first sample is accepted on the enabled edge where `xVal` is high. It is taken from channel 0's lane of `xIn`, where lane c occupies bits [c*DW +: DW]. Later enabled edges take lanes 1, 2, ... N-1, 0, ... in turn. Inputs seen before this alignment do not reach any result.
- R2: For channel c, the n-th result is formed from sum over k of h[c][k] * x_c[n-k], where x_c[m] = 0 for m < 0. The coefficient h[c][k] is the signed CW-bit field at bits [(c*TAPS+k)*CW +: CW] of the coefficient parameter and has FW fraction bits.
- R3: `yVal` first rises on the enabled edge numbered L, where the alignment edge is edge 1 and only enabled edges are counted. L = N*TAPS + 2*N + 2, plus 2 when rounding is on, plus 1 when clamping is on.
- R4: From the edge where `yVal` rises, each enabled edge writes exactly one lane of `yOut`. The lanes are written in channel order, starting at channel 0, and the other lanes hold.
- R5: On an edge with `en` low, no register changes. `yOut` and `yVal` hold, and no input sample is taken.
- R6: With rounding on, 2^(FW-1) is added to a non-negative sum and 2^(FW-1)-1 to a negative sum, and the result is then shifted right arithmetically by FW. This rounds half away from zero. With rounding off, the sum is only shifted, which is floor division.
- R7: With clamping on, a scaled result outside [-2^(DW-1), 2^(DW-1)-1] is replaced by the nearer limit. With clamping off, the result keeps its low DW bits, so it wraps.
- R8: Once aligned, a further `xVal` pulse changes neither the channel sequence nor any result.
- R9: Reset (`rstN` low, asynchronous) clears every sample, partial sum and output, and drops `yVal`. `yOut` stays zero until `yVal` rises. After reset, a new `xVal` re-aligns the channels with a cleared history.
- R10: The accumulator holds DW+CW+ceil(log2(TAPS)) bits, so full-scale inputs at every tap give the exact sum before scaling.
- R11: Once high, `yVal` stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Clock enable; low stalls all state |
| xVal | input | 1 | Marks channel 0's first sample |
| xIn | input | CH*DW | Signed sample lanes, lane c at [c*DW +: DW] |
| yVal | output | 1 | High from channel 0's first result onward |
| yOut | output | CH*DW | Signed result lanes, lane c at [c*DW +: DW] |

## Verification
The assertions assume that reset is applied before the first alignment strobe, and that `xIn` and `en` are known values at every clock edge. The stimulus holds reset over at least one edge before any strobe. It drives every lane with a defined value on every cycle, including lanes that are not being sampled. It changes inputs only on the falling edge. Re-alignment is attempted only through a reset pulse. The stray `xVal` pulses after alignment are there to show that the block ignores them, not to re-align it.

// File: rtl/ilfir_pkg.sv
package ilfir_pkg;

  // Per-edge strobes passed from sequencing control to the datapath.
  typedef struct packed {
    logic adv;    // enabled edge: every datapath register may move
    logic take;   // a channel sample is accepted on this edge
    logic wrOut;  // the formatted result lands in an output lane
  } ilfir_strobe_t;

endpackage

// File: rtl/ilfir_ctrl.sv
module ilfir_ctrl
  import ilfir_pkg::*;
#(
  parameter int CH  = 4,
  parameter int LAT = 46,
  localparam int CHW = (CH > 1) ? $clog2(CH) : 1,
  localparam int LCW = $clog2(LAT + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          en,
  input  logic          xVal,
  output ilfir_strobe_t stb,
  output logic [CHW-1:0] selCh,
  output logic [CHW-1:0] wrCh,
  output logic          yVal
);

  logic           aligned;
  logic [LCW-1:0] latCnt;
  logic [CHW-1:0] inCh;
  logic [CHW-1:0] outCh;
  logic           accept;

  function automatic logic [CHW-1:0] stepCh(input logic [CHW-1:0] c);
    return (c == CHW'(CH - 1)) ? '0 : c + 1'b1;
  endfunction

  assign accept    = aligned | xVal;
  assign stb.adv   = en;
  assign stb.take  = en & accept;
  assign stb.wrOut = en & (yVal | (aligned & (latCnt == LCW'(LAT - 1))));
  assign selCh     = inCh;
  assign wrCh      = outCh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aligned <= 1'b0;
      latCnt  <= '0;
      inCh    <= '0;
      outCh   <= '0;
      yVal    <= 1'b0;
    end else if (en) begin
      if (xVal) aligned <= 1'b1;
      if (accept) inCh <= stepCh(inCh);
      if (accept && !yVal) latCnt <= latCnt + 1'b1;
      if (stb.wrOut) begin
        yVal  <= 1'b1;
        outCh <= stepCh(outCh);
      end
    end
  end

endmodule

// File: rtl/ilfir_datapath.sv
module ilfir_datapath
  import ilfir_pkg::*;
#(
  parameter int CH    = 4,
  parameter int TAPS  = 8,
  parameter int DW    = 12,
  parameter int CW    = 12,
  parameter int FW    = 10,
  parameter bit ROUND = 1'b1,
  parameter bit SAT   = 1'b1,
  parameter logic [CH*TAPS*CW-1:0] COEF = '0,
  localparam int CHW  = (CH > 1) ? $clog2(CH) : 1,
  localparam int PW   = DW + CW,
  localparam int AW   = DW + CW + $clog2(TAPS),
  localparam int XLEN = 2 * CH * (TAPS - 1),
  localparam int PADN = 2 * CH - 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  ilfir_strobe_t   stb,
  input  logic [CHW-1:0]  selCh,
  input  logic [CHW-1:0]  wrCh,
  input  logic [CH*DW-1:0] xIn,
  output logic [CH*DW-1:0] yOut
);

  localparam int BIAS_POS = (FW > 0) ? (1 << (FW - 1)) : 0;
  localparam int BIAS_NEG = (FW > 0) ? BIAS_POS - 1 : 0;

  logic signed [DW-1:0] xSel;
  logic signed [DW-1:0] sReg;
  logic [CHW-1:0]       sCh;
  logic signed [DW-1:0] xDly [1:XLEN];
  logic signed [DW-1:0] tapX [TAPS];
  logic signed [PW-1:0] prodQ [TAPS];
  logic signed [AW-1:0] sumQ [TAPS][CH];
  logic signed [AW-1:0] padQ [PADN];
  logic signed [AW-1:0] scaled;
  logic signed [DW-1:0] fmt;
  logic signed [DW-1:0] yQ [CH];

  function automatic logic signed [CW-1:0] coefAt(input int ch, input int k);
    return COEF[(ch * TAPS + k) * CW +: CW];
  endfunction

  assign xSel = xIn[int'(selCh) * DW +: DW];

  always_comb begin
    tapX[0] = sReg;
    for (int k = 1; k < TAPS; k++) tapX[k] = xDly[2 * CH * k];
  end

  // Sample line, products and interleaved partial-sum chain.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sReg <= '0;
      sCh  <= '0;
      for (int i = 1; i <= XLEN; i++) xDly[i] <= '0;
      for (int k = 0; k < TAPS; k++) begin
        prodQ[k] <= '0;
        for (int j = 0; j < CH; j++) sumQ[k][j] <= '0;
      end
      for (int i = 0; i < PADN; i++) padQ[i] <= '0;
    end else if (stb.adv) begin
      sReg    <= stb.take ? xSel : '0;
      sCh     <= selCh;
      xDly[1] <= sReg;
      for (int i = 2; i <= XLEN; i++) xDly[i] <= xDly[i-1];
      for (int k = 0; k < TAPS; k++)
        prodQ[k] <= PW'(tapX[k]) * PW'(coefAt(int'(sCh), k));
      sumQ[0][0] <= AW'(prodQ[0]);
      for (int k = 1; k < TAPS; k++)
        sumQ[k][0] <= AW'(prodQ[k]) + sumQ[k-1][CH-1];
      for (int k = 0; k < TAPS; k++)
        for (int j = 1; j < CH; j++) sumQ[k][j] <= sumQ[k][j-1];
      padQ[0] <= sumQ[TAPS-1][CH-1];
      for (int i = 1; i < PADN; i++) padQ[i] <= padQ[i-1];
    end
  end

  // Scaling: symmetric rounding (two stages) or a plain floor shift.
  if (ROUND) begin : g_round
    logic signed [AW-1:0] biasQ;
    logic signed [AW-1:0] shQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        biasQ <= '0;
        shQ   <= '0;
      end else if (stb.adv) begin
        biasQ <= padQ[PADN-1] +
                 (padQ[PADN-1][AW-1] ? AW'(BIAS_NEG) : AW'(BIAS_POS));
        shQ   <= biasQ >>> FW;
      end
    end
    assign scaled = shQ;
  end else begin : g_trunc
    assign scaled = padQ[PADN-1] >>> FW;
  end

  // Range handling: registered clamp or combinational wrap.
  if (SAT) begin : g_clamp
    logic signed [DW-1:0] satQ;
    logic                 inRange;
    assign inRange = (&scaled[AW-1:DW-1]) | ~(|scaled[AW-1:DW-1]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) satQ <= '0;
      else if (stb.adv)
        satQ <= inRange ? scaled[DW-1:0]
                        : (scaled[AW-1] ? {1'b1, {(DW-1){1'b0}}}
                                        : {1'b0, {(DW-1){1'b1}}});
    end
    assign fmt = satQ;
  end else begin : g_wrap
    assign fmt = scaled[DW-1:0];
  end

  // Output demultiplexer: one lane written per enabled edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < CH; c++) yQ[c] <= '0;
    end else if (stb.adv && stb.wrOut) begin
      yQ[wrCh] <= fmt;
    end
  end

  for (genvar c = 0; c < CH; c++) begin : g_lane
    assign yOut[c*DW +: DW] = yQ[c];
  end

endmodule

// File: rtl/interleaved_fir.sv
module interleaved_fir
  import ilfir_pkg::*;
#(
  parameter int CH    = 4,
  parameter int TAPS  = 8,
  parameter int DW    = 12,
  parameter int CW    = 12,
  parameter int FW    = 10,
  parameter bit ROUND = 1'b1,
  parameter bit SAT   = 1'b1,
  parameter logic [CH*TAPS*CW-1:0] COEF = {(CH*TAPS){CW'(1 << FW)}},
  localparam int CHW = (CH > 1) ? $clog2(CH) : 1,
  localparam int LAT = CH * TAPS + 2 * CH + 2 + (ROUND ? 2 : 0) + (SAT ? 1 : 0)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            en,
  input  logic            xVal,
  input  logic [CH*DW-1:0] xIn,
  output logic            yVal,
  output logic [CH*DW-1:0] yOut
);

  if (CH < 1 || CH > 8) begin : g_bad_ch
    $error("channel count must be 1..8");
  end
  if (TAPS < 3 || CW < 2 || FW >= CW || FW < 0 || DW < 2) begin : g_bad_fmt
    $error("tap count or number format out of range");
  end

  ilfir_strobe_t  stb;
  logic [CHW-1:0] selCh;
  logic [CHW-1:0] wrCh;

  ilfir_ctrl #(.CH(CH), .LAT(LAT)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .en    (en),
    .xVal  (xVal),
    .stb   (stb),
    .selCh (selCh),
    .wrCh  (wrCh),
    .yVal  (yVal)
  );

  ilfir_datapath #(
    .CH(CH), .TAPS(TAPS), .DW(DW), .CW(CW), .FW(FW),
    .ROUND(ROUND), .SAT(SAT), .COEF(COEF)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .selCh (selCh),
    .wrCh  (wrCh),
    .xIn   (xIn),
    .yOut  (yOut)
  );

endmodule

// File: rtl/ilfir_checker.sv
module ilfir_checker #(
  parameter int CH = 4,
  parameter int DW = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            en,
  input logic            yVal,
  input logic [CH*DW-1:0] yOut
);

  logic [CH*DW-1:0] prevY;
  logic [CH-1:0]    chg;

  always_ff @(posedge clk) prevY <= yOut;

  always_comb
    for (int c = 0; c < CH; c++) chg[c] = prevY[c*DW +: DW] != yOut[c*DW +: DW];

  // R11
  yval_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    yVal |=> yVal);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> ($stable(yOut) && $stable(yVal)));

  // R4
  single_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(chg) <= 1);

  // R9
  quiet_before_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !yVal |-> (yOut == '0));

endmodule

bind interleaved_fir ilfir_checker #(.CH(CH), .DW(DW)) u_check (
  .clk  (clk),
  .rstN (rstN),
  .en   (en),
  .yVal (yVal),
  .yOut (yOut)
);

// File: tb/tb_interleaved_fir.sv
module tb_interleaved_fir;

  localparam int CH = 3, TAPS = 3, DW = 6, CW = 6, FW = 3;
  localparam int L_A = CH * TAPS + 2 * CH + 2 + 2 + 1;  // rounding + clamp
  localparam int L_B = CH * TAPS + 2 * CH + 2;          // floor + wrap

  function automatic int hTab(int c, int k);
    case (c * TAPS + k)
      0: return 31;  1: return -32; 2: return 5;
      3: return -7;  4: return 12;  5: return 3;
      6: return 1;   7: return 0;   8: return -19;
      default: return 0;
    endcase
  endfunction

  function automatic logic [CH*TAPS*CW-1:0] packCoef();
    logic [CH*TAPS*CW-1:0] v;
    v = '0;
    for (int c = 0; c < CH; c++)
      for (int k = 0; k < TAPS; k++) v[(c*TAPS+k)*CW +: CW] = CW'(hTab(c, k));
    return v;
  endfunction

  localparam logic [CH*TAPS*CW-1:0] COEF = packCoef();

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            en = 1'b0;
  logic            xVal = 1'b0;
  logic [CH*DW-1:0] xIn = '0;
  logic            yValA, yValB;
  logic [CH*DW-1:0] yOutA, yOutB;

  always #5 clk = ~clk;

  interleaved_fir #(.CH(CH), .TAPS(TAPS), .DW(DW), .CW(CW), .FW(FW),
                    .ROUND(1'b1), .SAT(1'b1), .COEF(COEF)) dut (
    .clk(clk), .rstN(rstN), .en(en), .xVal(xVal), .xIn(xIn),
    .yVal(yValA), .yOut(yOutA));

  interleaved_fir #(.CH(CH), .TAPS(TAPS), .DW(DW), .CW(CW), .FW(FW),
                    .ROUND(1'b0), .SAT(1'b0), .COEF(COEF)) dutRaw (
    .clk(clk), .rstN(rstN), .en(en), .xVal(xVal), .xIn(xIn),
    .yVal(yValB), .yOut(yOutB));

  int nChk = 0, nFail = 0;
  bit done = 0;
  int hist [CH][256];
  int nIn [CH];
  int ptr, edgeCnt, runOff;
  bit started, reasserted;
  bit seen [2];
  int wr [2];

  task automatic chk(bit ok, string tag, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int gen(int c, int i);
    if (i < 64) return ((i * 29 + c * 17 + runOff) % 64) - 32;
    if (i < 96) return (((i + c) % 2) == 1) ? 31 : -32;
    if (i < 128) return (i == 100) ? 8 : 0;
    return ((i * i + c * 5 + runOff) % 64) - 32;
  endfunction

  function automatic int lane(logic [CH*DW-1:0] v, int c);
    return int'($signed(v[c*DW +: DW]));
  endfunction

  function automatic int model(int c, int n, bit rnd, bit sat);
    int acc = 0;
    for (int k = 0; k < TAPS; k++)
      if (n - k >= 0) acc += hTab(c, k) * hist[c][n-k];
    if (rnd) acc += (acc >= 0) ? (1 << (FW - 1)) : (1 << (FW - 1)) - 1;
    acc = acc >>> FW;
    if (sat) begin
      if (acc > 31) acc = 31;
      if (acc < -32) acc = -32;
    end else begin
      acc = ((acc % 64) + 64) % 64;
      if (acc >= 32) acc -= 64;
    end
    return acc;
  endfunction

  task automatic checkDut(int d, logic yv, logic [CH*DW-1:0] yo,
                          logic [CH*DW-1:0] py, logic pv, bit enV, int lat,
                          bit rnd, bit sat);
    int c, n, e;
    string tag;
    if (!enV) begin
      chk(yo == py, "R5 lanes held while stalled", int'(yo), int'(py));
      chk(yv == pv, "R5 valid held while stalled", int'(yv), int'(pv));
      return;
    end
    if (!seen[d]) begin
      if (yv) begin
        chk(edgeCnt == lat, "R3 latency", edgeCnt, lat);
        seen[d] = 1;
      end else begin
        chk(yo == '0, "R9 quiet before valid", int'(yo), 0);
        return;
      end
    end else if (!yv) begin
      chk(0, "R11 valid dropped", 0, 1);
      return;
    end
    c = wr[d] % CH;
    n = wr[d] / CH;
    e = model(c, n, rnd, sat);
    tag = "R1 R2 R6 R7";
    if (n >= 64 && n < 96) tag = {tag, " R10"};
    if (reasserted) tag = {tag, " R8"};
    if (runOff != 0 && n < TAPS) tag = {tag, " R9"};
    chk(lane(yo, c) == e, tag, lane(yo, c), e);
    for (int o = 0; o < CH; o++)
      if (o != c) chk(lane(yo, o) == lane(py, o), "R4 other lane held",
                      lane(yo, o), lane(py, o));
    wr[d]++;
  endtask

  task automatic step(bit enV, bit xv);
    logic [CH*DW-1:0] pA, pB;
    logic pvA, pvB;
    bit acc;
    int v, ch;
    en = enV;
    xVal = xv;
    for (int c = 0; c < CH; c++) xIn[c*DW +: DW] = DW'(gen(c, nIn[c]));
    acc = enV && (started || xv);
    ch = started ? ptr : 0;
    v = gen(ch, nIn[ch]);
    pA = yOutA; pB = yOutB; pvA = yValA; pvB = yValB;
    @(posedge clk);
    @(negedge clk);
    if (acc) begin
      hist[ch][nIn[ch]] = v;
      nIn[ch]++;
      ptr = (ch + 1) % CH;
      started = 1;
      edgeCnt++;
    end
    checkDut(0, yValA, yOutA, pA, pvA, enV, L_A, 1'b1, 1'b1);
    checkDut(1, yValB, yOutB, pB, pvB, enV, L_B, 1'b0, 1'b0);
  endtask

  task automatic clearModel();
    for (int c = 0; c < CH; c++) begin
      nIn[c] = 0;
      for (int i = 0; i < 256; i++) hist[c][i] = 0;
    end
    ptr = 0; edgeCnt = 0; started = 0; reasserted = 0;
    seen[0] = 0; seen[1] = 0; wr[0] = 0; wr[1] = 0;
  endtask

  initial begin
    runOff = 0;
    clearModel();
    @(negedge clk);
    @(negedge clk);
    // R9: reset state
    chk(yValA == 0 && yValB == 0, "R9 valid low in reset", int'(yValA), 0);
    chk(yOutA == '0 && yOutB == '0, "R9 lanes zero in reset", int'(yOutA), 0);
    rstN = 1'b1;
    // R1: inputs before alignment are not taken
    for (int s = 0; s < 5; s++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int s = 0; s < 450; s++) begin
      bit enV, xv;
      enV = !((s >= 60 && s < 120 && (s % 4) == 1) || (s >= 200 && s < 205));
      xv = (s == 0) || (s >= 300 && s < 303);
      if (s >= 300) reasserted = 1;
      step(enV, xv);
    end
    // R9: reset mid-stream, then re-align with a different stream
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(yValA == 0 && yValB == 0, "R9 valid cleared", int'(yValA), 0);
    chk(yOutA == '0 && yOutB == '0, "R9 lanes cleared", int'(yOutA), 0);
    rstN = 1'b1;
    runOff = 23;
    clearModel();
    step(1'b1, 1'b0);
    for (int s = 0; s < 200; s++) step(1'b1, s == 0);
    chk(seen[0] && seen[1], "R3 valid reached after re-align", int'(seen[0]), 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

endmodule